// File: doc/BRIEF.md
# DMA Channel Interrupt Status Collector

This block collects the end-of-transfer and bus-error event pulses of a multi-channel DMA engine and presents them to a processor through a small register port. Each channel has two sticky flags, one per event class. A flag is set by a single-cycle pulse from the channel engine and is held until software clears it.

Software sees the flags in several views. There is a raw view of each class before any enable is applied, and a masked view of each class after the channel's enable bits are applied. There is also a merged view that ORs both masked classes into one bit per channel, so a handler can find the interrupting channel with a single read. A single interrupt line to the processor is the OR of the merged view.

Flags are cleared by writing ones to one of two class-specific clear addresses. The per-channel enable bits come in as plain inputs from each channel's own control and configuration settings.

Top module: `dma_irq_status`

## Requirements
- R1: A one-cycle pulse on `tc_pulse[i]` sets the raw end-of-transfer flag of channel i at that clock edge. The flag stays set until it is cleared.
- R2: A one-cycle pulse on `err_pulse[i]` sets the raw error flag of channel i at that clock edge. The flag stays set until it is cleared.
- R3: Reading address 1 returns the raw end-of-transfer flags and reading address 2 returns the raw error flags, with channel i in bit i and no enable applied.
- R4: Reading address 3 returns the raw end-of-transfer flags ANDed with `tc_en`. Reading address 4 returns the raw error flags ANDed with `err_en`.
- R5: Reading address 0 returns, for each channel i, the OR of its masked end-of-transfer bit and its masked error bit, in bit i.
- R6: A write to address 5 clears every raw end-of-transfer flag whose bit in `reg_wdata` is 1, and a write to address 6 does the same for the error flags. Bits written as 0 leave their flags unchanged, and neither address touches the other class.
- R7: When a set pulse and a clear write hit the same flag in the same cycle, the flag ends up set.
- R8: `irq` is registered. In the cycle after any channel has a nonzero merged bit it is 1, and otherwise it is 0.
- R9: Changing `tc_en` or `err_en` never changes a raw flag. It changes only the masked views, the merged view and `irq`.
- R10: `reg_rdata` is registered and shows the addressed view one cycle after `reg_addr` is presented. Bits at and above NUM_CH read 0. Addresses 5, 6 and 7 to 15 read 0. Writes to any address other than 5 or 6 have no effect.
- R11: After a synchronous reset all flags are clear, and `reg_rdata` and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tc_pulse | input | NUM_CH | Per-channel end-of-transfer event pulses |
| err_pulse | input | NUM_CH | Per-channel bus-error event pulses |
| tc_en | input | NUM_CH | Per-channel end-of-transfer interrupt enables |
| err_en | input | NUM_CH | Per-channel error interrupt enables |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Registered read data |
| irq | output | 1 | Processor interrupt request |

## Verification
Directed sequences come first:
- single pulses on one channel and one class, which show that the two classes land in their own flags;
- a set and a clear on the same bit in the same cycle, which separates set-wins from clear-wins;
- toggling the enables over fixed flags, which shows that masking never reaches the raw state;
- writes of zero bits and writes to read-only addresses, which must leave every flag intact.

Seeded random cycles then mix pulses, clear writes, enable patterns and read addresses. They are compared each cycle against a bench model of the flags. This exposes a wrong class mapping, lost sticky state or a misordered merged view, which the directed cases alone could miss.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int REG_AW = 4;

  typedef enum logic [REG_AW-1:0] {
    ADR_MERGED  = 4'd0,
    ADR_RAW_TC  = 4'd1,
    ADR_RAW_ERR = 4'd2,
    ADR_MSK_TC  = 4'd3,
    ADR_MSK_ERR = 4'd4,
    ADR_CLR_TC  = 4'd5,
    ADR_CLR_ERR = 4'd6
  } reg_adr_e;
endpackage

// File: rtl/dma_irq_flag_bank.sv
// Sticky flag bank: per-bit set pulse, write-one clear, set wins on collision.
module dma_irq_flag_bank #(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] set_i,
  input  logic [NUM_CH-1:0] clr_i,
  output logic [NUM_CH-1:0] flag_o
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) begin
        flag_o[i] <= 1'b0;
      end else if (set_i[i]) begin
        flag_o[i] <= 1'b1;
      end else if (clr_i[i]) begin
        flag_o[i] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dma_irq_read_mux.sv
// Registered read selection over the status views, zero-extended.
module dma_irq_read_mux
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [NUM_CH-1:0] merged_i,
  input  logic [NUM_CH-1:0] raw_tc_i,
  input  logic [NUM_CH-1:0] raw_err_i,
  input  logic [NUM_CH-1:0] msk_tc_i,
  input  logic [NUM_CH-1:0] msk_err_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [NUM_CH-1:0] sel;

  always_comb begin
    case (addr_i)
      ADR_MERGED:  sel = merged_i;
      ADR_RAW_TC:  sel = raw_tc_i;
      ADR_RAW_ERR: sel = raw_err_i;
      ADR_MSK_TC:  sel = msk_tc_i;
      ADR_MSK_ERR: sel = msk_err_i;
      default:     sel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_o <= '0;
    else     rdata_o <= DATA_W'(sel);
  end
endmodule

// File: rtl/dma_irq_status.sv
module dma_irq_status
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] tc_pulse,
  input  logic [NUM_CH-1:0] err_pulse,
  input  logic [NUM_CH-1:0] tc_en,
  input  logic [NUM_CH-1:0] err_en,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  logic [NUM_CH-1:0] tc_clr, err_clr;
  logic [NUM_CH-1:0] tc_raw, err_raw;
  logic [NUM_CH-1:0] tc_msk, err_msk, merged;

  assign tc_clr  = (reg_wr && reg_addr == ADR_CLR_TC)  ? reg_wdata[NUM_CH-1:0] : '0;
  assign err_clr = (reg_wr && reg_addr == ADR_CLR_ERR) ? reg_wdata[NUM_CH-1:0] : '0;

  dma_irq_flag_bank #(.NUM_CH(NUM_CH)) i_tc_bank (
    .clk(clk), .rst(rst), .set_i(tc_pulse), .clr_i(tc_clr), .flag_o(tc_raw)
  );

  dma_irq_flag_bank #(.NUM_CH(NUM_CH)) i_err_bank (
    .clk(clk), .rst(rst), .set_i(err_pulse), .clr_i(err_clr), .flag_o(err_raw)
  );

  assign tc_msk  = tc_raw & tc_en;
  assign err_msk = err_raw & err_en;
  assign merged  = tc_msk | err_msk;

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |merged;
  end

  dma_irq_read_mux #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) i_rd (
    .clk(clk), .rst(rst), .addr_i(reg_addr),
    .merged_i(merged), .raw_tc_i(tc_raw), .raw_err_i(err_raw),
    .msk_tc_i(tc_msk), .msk_err_i(err_msk), .rdata_o(reg_rdata)
  );
endmodule

// File: rtl/dma_irq_status_chk.sv
module dma_irq_status_chk #(
  parameter int NUM_CH = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [NUM_CH-1:0] tc_pulse,
  input logic [NUM_CH-1:0] err_pulse,
  input logic [NUM_CH-1:0] tc_en,
  input logic [NUM_CH-1:0] err_en,
  input logic [NUM_CH-1:0] tc_clr,
  input logic [NUM_CH-1:0] err_clr,
  input logic [NUM_CH-1:0] tc_raw,
  input logic [NUM_CH-1:0] err_raw,
  input logic              irq
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    // R1
    p_tc_set_r1: assert property (@(posedge clk) disable iff (rst)
      tc_pulse[i] |=> tc_raw[i]);
    p_tc_hold_r1: assert property (@(posedge clk) disable iff (rst)
      tc_raw[i] && !tc_clr[i] |=> tc_raw[i]);
    // R2
    p_err_set_r2: assert property (@(posedge clk) disable iff (rst)
      err_pulse[i] |=> err_raw[i]);
    p_err_hold_r2: assert property (@(posedge clk) disable iff (rst)
      err_raw[i] && !err_clr[i] |=> err_raw[i]);
    // R6
    p_tc_clear_r6: assert property (@(posedge clk) disable iff (rst)
      tc_clr[i] && !tc_pulse[i] |=> !tc_raw[i]);
    p_err_clear_r6: assert property (@(posedge clk) disable iff (rst)
      err_clr[i] && !err_pulse[i] |=> !err_raw[i]);
    // R7
    p_set_wins_r7: assert property (@(posedge clk) disable iff (rst)
      (tc_pulse[i] && tc_clr[i]) || (err_pulse[i] && err_clr[i])
      |=> (tc_raw[i] || !tc_pulse[i]) && (err_raw[i] || !err_pulse[i]));
    // R9: no flag rises without its pulse, whatever the enables do
    p_no_spurious_r9: assert property (@(posedge clk) disable iff (rst)
      !tc_raw[i] && !tc_pulse[i] && !err_raw[i] && !err_pulse[i]
      |=> !tc_raw[i] && !err_raw[i]);
  end

  // R8
  p_irq_on_r8: assert property (@(posedge clk) disable iff (rst)
    |((tc_raw & tc_en) | (err_raw & err_en)) |=> irq);
  p_irq_off_r8: assert property (@(posedge clk) disable iff (rst)
    ((tc_raw & tc_en) | (err_raw & err_en)) == '0 |=> !irq);
endmodule

bind dma_irq_status dma_irq_status_chk #(.NUM_CH(NUM_CH)) i_chk (
  .clk(clk), .rst(rst), .tc_pulse(tc_pulse), .err_pulse(err_pulse),
  .tc_en(tc_en), .err_en(err_en), .tc_clr(tc_clr), .err_clr(err_clr),
  .tc_raw(tc_raw), .err_raw(err_raw), .irq(irq)
);

// File: tb/test_dma_irq_status.sv
`timescale 1ns/1ps
module test_dma_irq_status;
  localparam int NCH = 8;
  localparam int DW  = 32;

  logic           clk = 1'b0;
  logic           rst;
  logic [NCH-1:0] tc_pulse, err_pulse, tc_en, err_en;
  logic           reg_wr;
  logic [3:0]     reg_addr;
  logic [DW-1:0]  reg_wdata;
  logic [DW-1:0]  reg_rdata;
  logic           irq;

  int checks = 0;
  int errors = 0;
  logic [NCH-1:0] m_tc, m_err;
  logic [DW-1:0]  exp_rd;
  logic           exp_irq;

  always #4 clk = ~clk;

  dma_irq_status #(.NUM_CH(NCH), .DATA_W(DW)) i_dma_irq_status (
    .clk(clk), .rst(rst), .tc_pulse(tc_pulse), .err_pulse(err_pulse),
    .tc_en(tc_en), .err_en(err_en), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  function automatic logic [DW-1:0] view(input logic [3:0] a,
      input logic [NCH-1:0] t, input logic [NCH-1:0] e,
      input logic [NCH-1:0] mt, input logic [NCH-1:0] me);
    logic [NCH-1:0] v;
    case (a)
      4'd0: v = (t & mt) | (e & me);
      4'd1: v = t;
      4'd2: v = e;
      4'd3: v = t & mt;
      4'd4: v = e & me;
      default: v = '0;
    endcase
    return DW'(v);
  endfunction

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One cycle: drive at negedge, model the edge, check at next negedge.
  task automatic step(input logic [NCH-1:0] st, input logic [NCH-1:0] se,
                      input logic wr, input logic [3:0] a, input logic [DW-1:0] wd,
                      input logic [NCH-1:0] mt, input logic [NCH-1:0] me, input string req);
    tc_pulse = st; err_pulse = se; reg_wr = wr; reg_addr = a;
    reg_wdata = wd; tc_en = mt; err_en = me;
    @(posedge clk);
    exp_rd  = view(a, m_tc, m_err, mt, me);
    exp_irq = |((m_tc & mt) | (m_err & me));
    if (wr && a == 4'd5) m_tc  = m_tc  & ~wd[NCH-1:0];
    if (wr && a == 4'd6) m_err = m_err & ~wd[NCH-1:0];
    m_tc  = m_tc  | st;
    m_err = m_err | se;
    @(negedge clk);
    check(req, reg_rdata, exp_rd);
    check("R8 irq", {31'd0, irq}, {31'd0, exp_irq});
  endtask

  task automatic idle_read(input logic [3:0] a, input string req);
    step('0, '0, 1'b0, a, '0, tc_en, err_en, req);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    void'($urandom(32'h1234_5678));
    rst = 1'b1; tc_pulse = '0; err_pulse = '0; tc_en = '0; err_en = '0;
    reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    m_tc = '0; m_err = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R11 reset rdata", reg_rdata, '0);
    check("R11 reset irq", {31'd0, irq}, 32'd0);

    // R1 / R2: single pulses land in their own class
    step(8'h04, '0, 1'b0, 4'd1, '0, '0, '0, "R1 tc set");
    idle_read(4'd1, "R1 tc raw held");
    idle_read(4'd2, "R2 err raw untouched by tc");
    step('0, 8'h80, 1'b0, 4'd2, '0, '0, '0, "R2 err set");
    idle_read(4'd2, "R2 err raw held");
    // R4 / R5 / R8 via enables; R9 raw unchanged
    step('0, '0, 1'b0, 4'd3, '0, 8'hFF, 8'h00, "R4 masked tc");
    idle_read(4'd4, "R4 masked err off");
    idle_read(4'd0, "R5 merged");
    step('0, '0, 1'b0, 4'd0, '0, 8'h00, 8'h80, "R5 merged err only");
    step('0, '0, 1'b0, 4'd1, '0, 8'h00, 8'h00, "R9 raw tc after mask off");
    idle_read(4'd2, "R9 raw err after mask off");
    // R6: zero bits ignored, one bits clear, class separation
    step('0, '0, 1'b1, 4'd5, 32'hFFFF_FFFB, '0, '0, "R10 clear addr reads zero");
    idle_read(4'd1, "R6 zero bit leaves tc flag");
    step('0, '0, 1'b1, 4'd5, 32'h0000_0004, '0, '0, "R10 clear addr reads zero");
    idle_read(4'd1, "R6 tc cleared");
    idle_read(4'd2, "R6 err untouched by tc clear");
    // R7: set and clear together
    step('0, 8'h80, 1'b1, 4'd6, 32'h80, '0, '0, "R10 clear addr reads zero");
    idle_read(4'd2, "R7 set wins");
    // R10: writes elsewhere ignored, unused addresses and upper bits read zero
    step('0, '0, 1'b1, 4'd2, 32'hFFFF_FFFF, '0, '0, "R10 write ignored");
    idle_read(4'd2, "R10 err kept after stray write");
    step('0, '0, 1'b1, 4'd15, 32'hFFFF_FFFF, '0, '0, "R10 unused addr");
    idle_read(4'd7, "R10 unused addr 7");

    // Random mix
    for (int n = 0; n < 400; n++) begin
      logic [NCH-1:0] st, se, mt, me;
      logic wr;
      logic [3:0] a;
      logic [DW-1:0] wd;
      st = (($urandom % 4) == 0) ? NCH'($urandom) : '0;
      se = (($urandom % 5) == 0) ? NCH'($urandom) : '0;
      mt = NCH'($urandom);
      me = NCH'($urandom);
      wr = (($urandom % 3) == 0);
      a  = (($urandom % 10) == 0) ? 4'($urandom) : 4'($urandom % 7);
      wd = $urandom;
      step(st, se, wr, a, wd, mt, me, "R1 R2 R3 R4 R5 R6 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule